// File: doc/BRIEF.md
# Multiplexed Address Latch and Data Buffer Control

This block connects a processor whose address and data share one set of lines to a backplane with separate address and data buses. When the address strobe falls, it captures a 15-bit word address and a memory-space select bit from the shared lines. It then holds that address on the backplane until the next strobe, whatever the shared lines do in the meantime. The processor numbers its lines with bit 0 as the most significant. The backplane numbers them the other way round, so the block reverses the bit order on every path.

The block also drives the enable and direction of a bidirectional data buffer. After the strobe falls, the buffer drives the address outward on the data lines as well. During a write, it carries the write data outward. During a read, it turns inward. The buffer never changes direction while it is enabled. When another master is granted the bus, the block stops driving every outgoing signal.

All strobes are active low and may arrive asynchronously. They are synchronised to a system clock that runs at least four times faster than the bus, and the shared lines pass through a matching delay so that they line up with the strobes.

Top module: `adbus_splitter`

## Requirements
- R1: During and after reset, before any strobe, `bp_addr` = 0, `bp_bios` = 0, `bp_addr_oe` = 1, `buf_oe_n` = 1 (disabled) and `buf_dir_out` = 1 (outbound).
- R2: A falling edge on `as_n` loads `bp_addr` and `bp_bios`. Both then stay unchanged until the next falling edge, even if `cpu_ad` or `cpu_space` change.
- R3: Bit order is reversed: `bp_addr[k]` = `cpu_ad[14-k]`, so `cpu_ad[0]` is the address MSB. `bp_bios` copies `cpu_space`, and 1 means BIOS space rather than main memory.
- R4: After the address strobe falls, and before any read or write strobe, the buffer is enabled outbound. `bp_dout[k]` then equals `cpu_ad[15-k]` as captured, so the data bus mirrors the address.
- R5: While `wr_n` is low, the buffer stays enabled outbound. `bp_dout[k]` follows `cpu_ad[15-k]`, delayed by the synchroniser depth.
- R6: After `rd_n` falls, the buffer is enabled inbound (`buf_dir_out` = 0). `cpu_din[k]` always equals `bp_din[15-k]`.
- R7: During a read, the buffer stays enabled inbound while either `rd_n` or `romsel_n` is low. It is disabled once both are high.
- R8: `buf_dir_out` changes only when `buf_oe_n` has been 1 in the cycle of the change and in the cycle before it, and `buf_oe_n` is still 1 in the cycle after the change.
- R9: While `hold_n` is low (synchronised), `bp_addr_oe` = 0 and `buf_oe_n` = 1, and falling edges on `as_n` do not load a new address. Once the hold ends, `bp_addr_oe` returns to 1.
- R10: When `wr_n` rises at the end of a write, the buffer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe; the address is captured on its falling edge |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| romsel_n | input | 1 | ROM select from the backplane decoder, active low |
| hold_n | input | 1 | Bus hold granted to another master, active low |
| cpu_ad | input | ADDR_W+1 | Shared processor lines; bit 0 is most significant |
| cpu_space | input | 1 | Memory-space select from the processor; 1 = BIOS space |
| bp_din | input | ADDR_W+1 | Backplane data arriving at the buffer |
| bp_addr | output | ADDR_W | Latched backplane address; bit 0 is least significant |
| bp_bios | output | 1 | Latched space select |
| bp_addr_oe | output | 1 | Drive enable for the address and control outputs |
| bp_dout | output | ADDR_W+1 | Outbound data toward the backplane |
| cpu_din | output | ADDR_W+1 | Inbound data toward the processor, in processor bit order |
| buf_oe_n | output | 1 | Data buffer enable, active low |
| buf_dir_out | output | 1 | Data buffer direction; 1 = toward the backplane |

## Verification
The bench builds the block with its default 15-bit address and two synchroniser stages. At those defaults every backplane bit position is reachable through a walking-one address pass and through random full-width patterns. The two-stage delay sets the latency, so each turnaround sequence finishes well inside the bench's settling windows. Random read and write cycles with random space bits are mixed with directed cases: shared lines changing after capture, a read whose strobe is released before the ROM select, and a strobe arriving during a hold. Together they reach every phase change of the buffer controller, including the inbound-to-outbound turnaround between back-to-back cycles.

// File: rtl/adbus_pkg.sv
`timescale 1ns/1ps
package adbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_WRITE = 3'd2,
        PH_READ  = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   en;
        logic   dir;
        logic   dis_prev;
        logic   chg;
        logic   addr_oe;
        logic   as_prev;
    } ctl_s;

endpackage

// File: rtl/adbus_sync.sv
`timescale 1ns/1ps
module adbus_sync #(
    parameter int WIDTH   = 1,
    parameter int STAGES  = 2,
    parameter bit RST_ONE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= {WIDTH{RST_ONE}};
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/adbus_latch.sv
`timescale 1ns/1ps
module adbus_latch #(
    parameter int ADDR_W = 15,
    localparam int AD_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wr_drive,
    input  logic [AD_W-1:0]   ad_dly,
    input  logic              space_dly,
    output logic [ADDR_W-1:0] bp_addr,
    output logic              bp_bios,
    output logic [AD_W-1:0]   bp_dout
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              bios;
        logic [AD_W-1:0]   dout;
    } lat_s;

    lat_s lat_d, lat_q;
    logic [ADDR_W-1:0] addr_rev;
    logic [AD_W-1:0]   word_rev;

    // processor bit 0 is the MSB; backplane bit 0 is the LSB
    for (genvar k = 0; k < ADDR_W; k++) begin : g_arev
        assign addr_rev[k] = ad_dly[ADDR_W-1-k];
    end
    for (genvar k = 0; k < AD_W; k++) begin : g_wrev
        assign word_rev[k] = ad_dly[AD_W-1-k];
    end

    always_comb begin
        lat_d = lat_q;
        if (capture) begin
            lat_d.addr = addr_rev;
            lat_d.bios = space_dly;
            lat_d.dout = word_rev;
        end else if (wr_drive) begin
            lat_d.dout = word_rev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign bp_addr = lat_q.addr;
    assign bp_bios = lat_q.bios;
    assign bp_dout = lat_q.dout;

endmodule

// File: rtl/adbus_bufctl.sv
`timescale 1ns/1ps
module adbus_bufctl
    import adbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_s_n,
    input  logic rd_s_n,
    input  logic wr_s_n,
    input  logic rom_s_n,
    input  logic hold_s,
    output logic as_fall,
    output logic wr_drive,
    output logic buf_oe_n,
    output logic buf_dir_out,
    output logic addr_oe
);

    ctl_s ctl_d, ctl_q;
    logic want_en;
    logic want_dir;

    assign as_fall = ctl_q.as_prev & ~as_s_n;

    always_comb begin
        want_en  = (ctl_q.phase == PH_ADDR) || (ctl_q.phase == PH_WRITE) ||
                   (ctl_q.phase == PH_READ);
        want_dir = (ctl_q.phase != PH_READ);
    end

    assign wr_drive = ~wr_s_n & ~hold_s &
                      ((ctl_q.phase == PH_ADDR) || (ctl_q.phase == PH_WRITE));

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.as_prev  = as_s_n;
        ctl_d.addr_oe  = ~hold_s;
        ctl_d.dis_prev = ~ctl_q.en;
        ctl_d.chg      = 1'b0;

        // bus phase
        if (hold_s) begin
            ctl_d.phase = PH_HOLD;
        end else if (as_fall) begin
            ctl_d.phase = PH_ADDR;
        end else begin
            unique case (ctl_q.phase)
                PH_HOLD:  ctl_d.phase = PH_IDLE;
                PH_ADDR: begin
                    if (!wr_s_n)      ctl_d.phase = PH_WRITE;
                    else if (!rd_s_n) ctl_d.phase = PH_READ;
                end
                PH_WRITE: if (wr_s_n) ctl_d.phase = PH_IDLE;
                PH_READ:  if (rd_s_n && rom_s_n) ctl_d.phase = PH_IDLE;
                default:  ctl_d.phase = ctl_q.phase;
            endcase
        end

        // buffer sequencing: drop enable, wait, turn, wait, enable
        if (hold_s) begin
            ctl_d.en = 1'b0;
        end else if (ctl_q.en) begin
            if (!want_en || (want_dir != ctl_q.dir)) begin
                ctl_d.en = 1'b0;
            end
        end else if (want_dir != ctl_q.dir) begin
            if (ctl_q.dis_prev) begin
                ctl_d.dir = want_dir;
                ctl_d.chg = 1'b1;
            end
        end else if (want_en && !ctl_q.chg) begin
            ctl_d.en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase    <= PH_IDLE;
            ctl_q.en       <= 1'b0;
            ctl_q.dir      <= 1'b1;
            ctl_q.dis_prev <= 1'b1;
            ctl_q.chg      <= 1'b0;
            ctl_q.addr_oe  <= 1'b1;
            ctl_q.as_prev  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign buf_oe_n    = ~ctl_q.en;
    assign buf_dir_out = ctl_q.dir;
    assign addr_oe     = ctl_q.addr_oe;

endmodule

// File: rtl/adbus_splitter.sv
`timescale 1ns/1ps
module adbus_splitter #(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2,
    localparam int AD_W       = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              romsel_n,
    input  logic              hold_n,
    input  logic [AD_W-1:0]   cpu_ad,
    input  logic              cpu_space,
    input  logic [AD_W-1:0]   bp_din,
    output logic [ADDR_W-1:0] bp_addr,
    output logic              bp_bios,
    output logic              bp_addr_oe,
    output logic [AD_W-1:0]   bp_dout,
    output logic [AD_W-1:0]   cpu_din,
    output logic              buf_oe_n,
    output logic              buf_dir_out
);

    localparam int NSTB = 5;

    logic [NSTB-1:0] stb_s;
    logic [AD_W:0]   bus_dly;
    logic            hold_s;
    logic            as_fall;
    logic            wr_drive;

    adbus_sync #(.WIDTH(NSTB), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_stb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hold_n, romsel_n, rd_n, wr_n, as_n}),
        .q     (stb_s)
    );

    // same depth as the strobes so the captured word matches the edge
    adbus_sync #(.WIDTH(AD_W + 1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_bus_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cpu_space, cpu_ad}),
        .q     (bus_dly)
    );

    assign hold_s = ~stb_s[4];

    adbus_bufctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_s_n      (stb_s[0]),
        .rd_s_n      (stb_s[2]),
        .wr_s_n      (stb_s[1]),
        .rom_s_n     (stb_s[3]),
        .hold_s      (hold_s),
        .as_fall     (as_fall),
        .wr_drive    (wr_drive),
        .buf_oe_n    (buf_oe_n),
        .buf_dir_out (buf_dir_out),
        .addr_oe     (bp_addr_oe)
    );

    adbus_latch #(.ADDR_W(ADDR_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (as_fall & ~hold_s),
        .wr_drive  (wr_drive),
        .ad_dly    (bus_dly[AD_W-1:0]),
        .space_dly (bus_dly[AD_W]),
        .bp_addr   (bp_addr),
        .bp_bios   (bp_bios),
        .bp_dout   (bp_dout)
    );

    for (genvar k = 0; k < AD_W; k++) begin : g_inrev
        assign cpu_din[k] = bp_din[AD_W-1-k];
    end

endmodule

// File: rtl/adbus_splitter_chk.sv
`timescale 1ns/1ps
module adbus_splitter_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_s,
    input logic              as_fall,
    input logic              buf_oe_n,
    input logic              buf_dir_out,
    input logic              bp_addr_oe,
    input logic [ADDR_W-1:0] bp_addr,
    input logic              bp_bios
);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_fall |=> ($stable(bp_addr) && $stable(bp_bios)));

    p_dir_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_dir_out) |-> (buf_oe_n && $past(buf_oe_n)));

    p_dir_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_dir_out) |=> buf_oe_n);

    p_enable_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_oe_n) |-> $stable(buf_dir_out));

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> (buf_oe_n && !bp_addr_oe));

    p_hold_nocap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> $stable(bp_addr));

endmodule

bind adbus_splitter adbus_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_s      (hold_s),
    .as_fall     (as_fall),
    .buf_oe_n    (buf_oe_n),
    .buf_dir_out (buf_dir_out),
    .bp_addr_oe  (bp_addr_oe),
    .bp_addr     (bp_addr),
    .bp_bios     (bp_bios)
);

// File: tb/adbus_splitter_tb.sv
`timescale 1ns/1ps
module adbus_splitter_tb;

    localparam int AW = 15;
    localparam int DW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          as_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, romsel_n = 1'b1, hold_n = 1'b1;
    logic [DW-1:0] cpu_ad = '0;
    logic          cpu_space = 1'b0;
    logic [DW-1:0] bp_din = '0;
    logic [AW-1:0] bp_addr;
    logic          bp_bios, bp_addr_oe, buf_oe_n, buf_dir_out;
    logic [DW-1:0] bp_dout, cpu_din;

    int total = 0;
    int bad = 0;
    int r8_viol = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adbus_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n),
        .romsel_n(romsel_n), .hold_n(hold_n), .cpu_ad(cpu_ad), .cpu_space(cpu_space),
        .bp_din(bp_din), .bp_addr(bp_addr), .bp_bios(bp_bios), .bp_addr_oe(bp_addr_oe),
        .bp_dout(bp_dout), .cpu_din(cpu_din), .buf_oe_n(buf_oe_n), .buf_dir_out(buf_dir_out)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [DW-1:0] ad);
        logic [AW-1:0] r;
        for (int k = 0; k < AW; k++) r[k] = ad[AW-1-k];
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_word(input logic [DW-1:0] w);
        logic [DW-1:0] r;
        for (int k = 0; k < DW; k++) r[k] = w[DW-1-k];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R8 monitor: direction turns only inside a disabled window
    logic prev_oe_n = 1'b1, prev_dir = 1'b1, prev_turn = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_dir_out !== prev_dir && !(buf_oe_n && prev_oe_n)) r8_viol++;
            if (prev_turn && !buf_oe_n) r8_viol++;
            prev_turn = (buf_dir_out !== prev_dir);
        end
        prev_oe_n = buf_oe_n;
        prev_dir  = buf_dir_out;
    end

    task automatic bus_cycle(input bit is_wr, input logic [DW-1:0] ad, input logic sp,
                             input logic [DW-1:0] wdata, input logic [DW-1:0] rdata,
                             input bit early_rd_release);
        cpu_ad = ad; cpu_space = sp; as_n = 1'b0;
        tick(10);
        chk("R2/R3 addr", 32'(bp_addr), 32'(exp_addr(ad)));
        chk("R3 space", 32'(bp_bios), 32'(sp));
        chk("R4 enabled", 32'(buf_oe_n), 32'd0);
        chk("R4 outbound", 32'(buf_dir_out), 32'd1);
        chk("R4 mirror", 32'(bp_dout), 32'(exp_word(ad)));
        cpu_ad = DW'($urandom); cpu_space = ~sp;
        tick(6);
        chk("R2 addr held", 32'(bp_addr), 32'(exp_addr(ad)));
        chk("R2 space held", 32'(bp_bios), 32'(sp));
        if (is_wr) begin
            cpu_ad = wdata; wr_n = 1'b0;
            tick(8);
            chk("R5 wdata", 32'(bp_dout), 32'(exp_word(wdata)));
            chk("R5 outbound on", 32'({buf_oe_n, buf_dir_out}), 32'b01);
            wr_n = 1'b1;
            tick(8);
            chk("R10 write end", 32'(buf_oe_n), 32'd1);
        end else begin
            romsel_n = 1'b0; rd_n = 1'b0; bp_din = rdata;
            tick(10);
            chk("R6 inbound on", 32'({buf_oe_n, buf_dir_out}), 32'b00);
            chk("R6 read data", 32'(cpu_din), 32'(exp_word(rdata)));
            if (early_rd_release) begin
                rd_n = 1'b1;
                tick(8);
                chk("R7 select still low", 32'({buf_oe_n, buf_dir_out}), 32'b00);
                romsel_n = 1'b1;
            end else begin
                rd_n = 1'b1; romsel_n = 1'b1;
            end
            tick(8);
            chk("R7 released", 32'(buf_oe_n), 32'd1);
        end
        as_n = 1'b1;
        tick(4);
    endtask

    initial begin
        void'($urandom(32'd24681));
        tick(4);
        chk("R1 addr", 32'(bp_addr), 32'd0);
        chk("R1 oe", 32'({buf_oe_n, buf_dir_out, bp_addr_oe}), 32'b111);
        rst_n = 1'b1;
        tick(6);
        chk("R1 idle after reset", 32'({bp_bios, buf_oe_n, buf_dir_out, bp_addr_oe}), 32'b0111);
        chk("R1 addr after reset", 32'(bp_addr), 32'd0);

        // walking one through every address position (R3)
        for (int i = 0; i < AW; i++) begin
            bus_cycle(1'b1, DW'(1) << i, i[0], DW'($urandom), '0, 1'b0);
        end

        // corner: read with rd released before the ROM select (R7)
        bus_cycle(1'b0, 16'h0002, 1'b1, '0, 16'h8001, 1'b1);
        bus_cycle(1'b1, 16'hFFFE, 1'b0, 16'h5AA5, '0, 1'b0);

        // hold: outputs quiet, strobe ignored (R9)
        hold_n = 1'b0;
        tick(6);
        chk("R9 hold quiet", 32'({bp_addr_oe, buf_oe_n}), 32'b01);
        cpu_ad = 16'h1234; as_n = 1'b0;
        tick(8);
        chk("R9 no capture", 32'(bp_addr), 32'(exp_addr(16'hFFFE)));
        hold_n = 1'b1;
        tick(6);
        chk("R9 hold released", 32'(bp_addr_oe), 32'd1);
        chk("R9 still disabled", 32'(buf_oe_n), 32'd1);
        as_n = 1'b1;
        tick(4);

        // random mix of reads and writes
        for (int i = 0; i < 60; i++) begin
            bus_cycle(1'($urandom), DW'($urandom), 1'($urandom), DW'($urandom),
                      DW'($urandom), 1'($urandom));
        end

        chk("R8 turnaround gaps", 32'(r8_viol), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule